// File: doc/BRIEF.md
# Double-Buffered DAC Word Loader

This block is the digital front end of a 16-bit digital-to-analog converter. A host delivers a data word over a handful of slow pins, either one bit per strobe or as two separate bytes. The word collects in an input (first-rank) register. A separate load level copies it into the output (second-rank) register that drives the converter code. Because the two ranks are separate, several converters can be filled one after another and then updated together.

All host pins are slow compared with the block clock and pass through synchronizers. The strobe acts on its rising edge. The enables and the load pin act on their levels. In serial mode the input register works as a shift register, and the bit that falls out is presented on a chain output so that converters can be cascaded. A clear pin forces the converter code to unipolar zero or to bipolar midscale without waiting for a clock. The input register keeps its contents through a clear, so a later load restores the previous word.

Top module: `dual_rank_dac_if`

## Requirements
- R1: In byte mode (`byte_mode_in` high), a rising edge of `strobe_in` writes `data_in` into bits 15:8 of the input register while `hi_en_in` is high, and into bits 7:0 while `lo_en_in` is high. The two halves may be written in either order.
- R2: In serial mode (`byte_mode_in` low) with `data_in[1]` high, each strobe rising edge shifts the input register one place toward bit 15 and enters `data_in[0]` at bit 0. `chain_out` then shows bit 15, which is the next bit to leave.
- R3: In serial mode with `data_in[1]` low, each strobe rising edge shifts the register toward bit 0 and enters `data_in[0]` at bit 15. `chain_out` then shows bit 0.
- R4: In serial mode `hi_en_in` has no effect on the input register.
- R5: While `load_in` is high and no clear is active, the input register is copied into `dac_code`. A pin change reaches `dac_code` two clocks after the synchronizers capture it.
- R6: The strobe acts only on its rising edge. Holding it high while `data_in` changes causes no further shift.
- R7: While `clear_in` is high, `dac_code` is 16'h0000 if `lo_en_in` is low and 16'h8000 if it is high. This takes effect without waiting for a clock edge, and the output register keeps that value after the clear is released.
- R8: A clear leaves the input register unchanged, so a later load restores the previously loaded word.
- R9: A clear takes priority over a load that is held high at the same time.
- R10: When `rst_n` is low at a clock edge, both registers become zero and `chain_out` becomes 0.
- R11: In byte mode `chain_out` shows bit 15 of the input register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the host pins |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_in | input | 1 | Write/shift strobe; acts on its rising edge |
| byte_mode_in | input | 1 | High selects byte mode, low selects serial mode |
| data_in | input | 8 | Byte data; in serial mode bit 0 is the serial data and bit 1 is the bit order (1 = MSB first) |
| hi_en_in | input | 1 | High-byte enable in byte mode |
| lo_en_in | input | 1 | Low-byte enable in byte mode; in both modes it selects the clear target (1 = midscale) |
| load_in | input | 1 | Level: copies the input register to the output register |
| clear_in | input | 1 | Clear of the output register; acts without a clock, released synchronously |
| chain_out | output | 1 | Serial cascade output |
| dac_code | output | 16 | Converter code |

## Verification
On every cycle, the assertions check how each strobe edge changes the input register in the two serial bit orders. They also check that the register stays put between edges, that a load copies the word, that the output register holds when neither load nor clear is active, that a clear shows only one of the two legal codes, and that a clear wins over a load. Other behaviours need the bench's scenarios: halves written in either order, a word restored after a clear, the cascade bit that leaves while the previous word is shifted out, and the clock-free onset of a clear. The bench also runs a behavioural reference model with the full synchronizer latency and compares it with the outputs on every clock.

// File: rtl/dacif_pkg.sv
// Package: shared widths and the bundle of synchronized host pins.
// Assumes the word is exactly two bytes wide.
package dacif_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              strobe;
        logic              byte_mode;
        logic [BYTE_W-1:0] data;
        logic              hi_en;
        logic              lo_en;
        logic              load;
    } pin_bus_t;
endpackage

// File: rtl/dacif_sync.sv
// Multi-stage synchronizer for a vector of slow host pins.
// Assumes each bit is independent; the pins are level signals held for several clocks.
module dacif_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one register of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_input_rank.sv
// First-rank register: byte writes or serial shift on each strobe edge.
// Assumes synchronized inputs and a one-cycle strobe_edge pulse.
module dacif_input_rank
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_edge,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] data,
    input  logic              hi_en,
    input  logic              lo_en,
    output logic [WORD_W-1:0] word,
    output logic              chain_out
);
    logic serial_bit;
    logic msb_first;

    assign serial_bit = data[0];
    assign msb_first  = data[1];

    // Purpose: update the first-rank word on a strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (strobe_edge) begin
            if (!byte_mode) begin
                if (msb_first)
                    word <= {word[WORD_W-2:0], serial_bit};
                else
                    word <= {serial_bit, word[WORD_W-1:1]};
            end else begin
                if (hi_en) word[WORD_W-1 -: BYTE_W] <= data;
                if (lo_en) word[BYTE_W-1:0]         <= data;
            end
        end
    end

    // Purpose: select the cascade bit for the current mode and order.
    always_comb begin
        if (byte_mode || msb_first)
            chain_out = word[WORD_W-1];
        else
            chain_out = word[0];
    end

    p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_edge |=> $stable(word));
    p_msb_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_edge && !byte_mode && msb_first) |=>
        (word == {$past(word[WORD_W-2:0]), $past(serial_bit)}));
    p_lsb_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_edge && !byte_mode && !msb_first) |=>
        (word == {$past(serial_bit), $past(word[WORD_W-1:1])}));
    p_hi_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_edge && !byte_mode && hi_en && msb_first) |=>
        (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (word == '0));
endmodule

// File: rtl/dacif_output_rank.sv
// Second-rank register: level load, asynchronous clear to zero or midscale.
// Assumes clear_in is raw and the other inputs are synchronized.
module dacif_output_rank
    import dacif_pkg::*;
#(
    parameter int CLR_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_in,
    input  logic              clear_to_mid,
    input  logic              load,
    input  logic [WORD_W-1:0] first_word,
    output logic [WORD_W-1:0] dac_code
);
    localparam logic [WORD_W-1:0] MID_CODE = {1'b1, {(WORD_W-1){1'b0}}};

    logic [CLR_STAGES-1:0] clr_hold;
    logic                  clr_active;
    logic [WORD_W-1:0]     clr_target;
    logic [WORD_W-1:0]     dac_q;

    // Purpose: set at once by clear, release after CLR_STAGES clocks.
    always_ff @(posedge clk or posedge clear_in) begin
        if (clear_in)
            clr_hold <= '1;
        else if (!rst_n)
            clr_hold <= '0;
        else
            clr_hold <= {clr_hold[CLR_STAGES-2:0], 1'b0};
    end

    assign clr_active = clear_in | clr_hold[CLR_STAGES-1];
    assign clr_target = clear_to_mid ? MID_CODE : '0;

    // Purpose: second-rank register; clear wins over load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_q <= '0;
        else if (clr_active)
            dac_q <= clr_target;
        else if (load)
            dac_q <= first_word;
    end

    assign dac_code = clr_active ? clr_target : dac_q;

    p_clear_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_in |-> (dac_code == '0 || dac_code == MID_CODE));
    p_clear_beats_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_in && load) |=> (dac_q == '0 || dac_q == MID_CODE));
    p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr_active) |=> (dac_q == $past(first_word)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr_active) |=> $stable(dac_q));
endmodule

// File: rtl/dual_rank_dac_if.sv
// Top: synchronizes host pins, detects strobe edges, feeds both ranks.
// Assumes host pins change slowly relative to clk.
module dual_rank_dac_if
    import dacif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_in,
    input  logic              byte_mode_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              hi_en_in,
    input  logic              lo_en_in,
    input  logic              load_in,
    input  logic              clear_in,
    output logic              chain_out,
    output logic [WORD_W-1:0] dac_code
);
    localparam int PIN_W = $bits(pin_bus_t);

    pin_bus_t          raw_pins;
    pin_bus_t          pins;
    logic [PIN_W-1:0]  pins_vec;
    logic              strobe_prev;
    logic              strobe_edge;
    logic [WORD_W-1:0] first_word;

    assign raw_pins = '{strobe: strobe_in, byte_mode: byte_mode_in, data: data_in,
                        hi_en: hi_en_in, lo_en: lo_en_in, load: load_in};

    dacif_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_pins),
        .sync_out (pins_vec)
    );
    assign pins = pin_bus_t'(pins_vec);

    // Purpose: remember the previous synchronized strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_prev <= 1'b0;
        else
            strobe_prev <= pins.strobe;
    end

    assign strobe_edge = pins.strobe & ~strobe_prev;

    dacif_input_rank u_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_edge (strobe_edge),
        .byte_mode   (pins.byte_mode),
        .data        (pins.data),
        .hi_en       (pins.hi_en),
        .lo_en       (pins.lo_en),
        .word        (first_word),
        .chain_out   (chain_out)
    );

    dacif_output_rank #(.CLR_STAGES(2)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_in     (clear_in),
        .clear_to_mid (pins.lo_en),
        .load         (pins.load),
        .first_word   (first_word),
        .dac_code     (dac_code)
    );

    p_edge_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> !strobe_edge);
endmodule

// File: tb/dual_rank_dac_if_tb.sv
module dual_rank_dac_if_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0, bmode = 1'b1, hi = 1'b0, lo = 1'b0, ld = 1'b0, clr = 1'b0;
    logic [7:0] db = 8'h00;
    logic chain;
    logic [15:0] code;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    dual_rank_dac_if u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe), .byte_mode_in(bmode),
        .data_in(db), .hi_en_in(hi), .lo_en_in(lo), .load_in(ld),
        .clear_in(clr), .chain_out(chain), .dac_code(code)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Reference model; pin bits: 0 strobe,1 mode,9:2 data,10 hi,11 lo,12 load,13 clear
    logic [13:0] h1 = '0, h2 = '0, h3 = '0, cur;
    logic [15:0] m_word = '0, m_dac = '0, old_w, exp_code;
    logic act_b, edg, exp_chain;

    always @(posedge clk) begin
        cur = {clr, ld, lo, hi, db, bmode, strobe};
        if (!rst_n) begin
            m_word = '0; m_dac = '0; h1 = '0; h2 = '0; h3 = '0;
        end else begin
            act_b = cur[13] | h1[13] | h2[13];
            edg   = h2[0] & ~h3[0];
            old_w = m_word;
            if (edg) begin
                if (!h2[1]) begin
                    if (h2[3]) m_word = {old_w[14:0], h2[2]};
                    else       m_word = {h2[2], old_w[15:1]};
                end else begin
                    if (h2[10]) m_word[15:8] = h2[9:2];
                    if (h2[11]) m_word[7:0]  = h2[9:2];
                end
            end
            if (act_b)       m_dac = h2[11] ? 16'h8000 : 16'h0000;
            else if (h2[12]) m_dac = old_w;
            h3 = h2; h2 = h1; h1 = cur;
        end
        #1;
        exp_code  = (clr | h1[13] | h2[13]) ? (h2[11] ? 16'h8000 : 16'h0000) : m_dac;
        exp_chain = (h2[1] | h2[3]) ? m_word[15] : m_word[0];
        if (rst_n) begin
            chk({cur_req, " model code"}, code, exp_code);
            chk({cur_req, " model chain"}, {15'd0, chain}, {15'd0, exp_chain});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        step(1); strobe = 1'b1; step(4); strobe = 1'b0; step(4);
    endtask

    task automatic load_word();
        ld = 1'b1; step(4); ld = 1'b0; step(4);
    endtask

    task automatic send_serial(input logic [15:0] w, input logic msb_first);
        for (int i = 0; i < 16; i++) begin
            db[1] = msb_first;
            db[0] = msb_first ? w[15 - i] : w[i];
            pulse_strobe();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R10 reset code", code, 16'h0000);
        chk("R10 reset chain", {15'd0, chain}, 16'h0000);

        // R1: high byte then low byte
        cur_req = "R1";
        db = 8'hA5; hi = 1'b1; pulse_strobe(); hi = 1'b0;
        db = 8'h3C; lo = 1'b1; pulse_strobe(); lo = 1'b0;
        step(3);
        chk("R11 byte chain msb=1", {15'd0, chain}, 16'h0001);
        load_word();
        chk("R1 R5 hi-then-lo", code, 16'hA53C);
        // R1: low byte then high byte
        db = 8'h11; lo = 1'b1; pulse_strobe(); lo = 1'b0;
        db = 8'h7E; hi = 1'b1; pulse_strobe(); hi = 1'b0;
        step(3);
        chk("R11 byte chain msb=0", {15'd0, chain}, 16'h0000);
        load_word();
        chk("R1 lo-then-hi", code, 16'h7E11);

        // R2: serial MSB first, cascade bit, hi enable held (R4)
        cur_req = "R2";
        bmode = 1'b0; db = 8'h02; step(4);
        pulse_strobe();
        step(3);
        chk("R2 chain shows old bit14", {15'd0, chain}, 16'h0001);
        hi = 1'b1;
        send_serial(16'hC3A1, 1'b1);
        hi = 1'b0;
        step(3);
        chk("R2 chain after word", {15'd0, chain}, 16'h0001);
        load_word();
        chk("R2 R4 msb-first word", code, 16'hC3A1);

        // R3: serial LSB first
        cur_req = "R3";
        send_serial(16'h5A0F, 1'b0);
        step(3);
        chk("R3 chain shows bit0", {15'd0, chain}, 16'h0001);
        load_word();
        chk("R3 lsb-first word", code, 16'h5A0F);

        // R6: one shift per rising edge only
        cur_req = "R6";
        db = 8'h01; step(1); strobe = 1'b1;
        for (int i = 0; i < 10; i++) begin step(1); db[0] = ~db[0]; end
        strobe = 1'b0; step(4);
        load_word();
        chk("R6 single shift", code, 16'hAD07);

        // R7 midscale clear, R9 clear beats load, R8 restore
        cur_req = "R7";
        lo = 1'b1; step(4);
        ld = 1'b1; step(1);
        clr = 1'b1; #1;
        chk("R7 immediate midscale", code, 16'h8000);
        step(5);
        chk("R9 clear beats load", code, 16'h8000);
        cur_req = "R8";
        clr = 1'b0; step(5);
        chk("R8 R9 word back after release", code, 16'hAD07);
        ld = 1'b0; step(2);

        // R7 zero clear, held after release
        cur_req = "R7";
        lo = 1'b0; step(4);
        clr = 1'b1; #1;
        chk("R7 immediate zero", code, 16'h0000);
        step(3); clr = 1'b0; step(5);
        chk("R7 zero held after release", code, 16'h0000);
        cur_req = "R8";
        load_word();
        chk("R8 restore after clear", code, 16'hAD07);

        // R10: reset mid-operation
        cur_req = "R10";
        rst_n = 1'b0; step(2);
        chk("R10 reset clears output", code, 16'h0000);
        rst_n = 1'b1; step(2);
        load_word();
        chk("R10 first rank cleared", code, 16'h0000);

        step(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule